// File: doc/BRIEF.md
# Triggered Acquisition Sequencer

This block runs one capture pass for a front-end test board clocked at 40 MHz. The host pulses a start bit, and the sequencer then waits for a trigger. The trigger can be a software command or an external input. After a programmable latency, the sequencer opens a write window of a fixed number of points into a spy buffer. Each point is one wide word made of several 12-bit channels. When the last point is written, it raises an end-of-run flag and holds it. The host polls that flag before draining the buffer.

The written word can come from the live ADC channels or from stand-in test data. The test data is either fixed constants or a counter tied to the write index. In both test modes the top bit of the last channel carries a shaped pulse, which starts when the trigger is accepted. This lets the captured record show where the trigger fell relative to the window. The buffer memory and the host transport sit outside the block. The block only drives the buffer's write enable, address and data.

Top module: `acq_sequencer`

## Requirements
- R1: When the sequencer is idle, a one-cycle start pulse makes busy_o high and done_o low on the next cycle, and clears the write index.
- R2: A trigger is the OR of soft_trig_i and ext_trig_i. It is accepted only while the sequencer is armed (started and not yet triggered). A trigger while idle causes no write and leaves busy_o low.
- R3: A trigger accepted at clock edge T with latency L >= 1 gives the first buffer write at edge T+L. A latency of 0 behaves like 1.
- R4: Each run writes exactly DEPTH words, at addresses 0, 1, ..., DEPTH-1, on consecutive cycles with no gap.
- R5: On the cycle after the write to address DEPTH-1, busy_o falls and done_o rises. done_o then stays high until the next accepted start.
- R6: A start pulse while busy_o is high has no effect: the run's timing, addresses and length do not change.
- R7: A second trigger after the one that was accepted, during the latency wait or the write window, has no effect on timing, addresses or the pulse bit.
- R8: Source mode 0 or 3 on src_mode_i passes adc_i unchanged to wr_data_o.
- R9: In source mode 1, channel k (bits 12k+11 down to 12k) carries 0x456 for even k and 0xABC for odd k. Bit 11 of the last channel is replaced by the pulse.
- R10: In source mode 2, channel k carries (write index + k) mod 4096. Bit 11 of the last channel is replaced by the pulse.
- R11: The pulse is high for PULSE_LEN cycles starting on the cycle after the accepted trigger. In test modes, the word at write index i therefore has that bit set exactly when L+i <= PULSE_LEN (with L taken as 1 if it is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 40 MHz clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Host start request, one-cycle pulse |
| soft_trig_i | input | 1 | Software trigger pulse |
| ext_trig_i | input | 1 | External trigger pulse |
| latency_i | input | LAT_W | Trigger-to-capture delay in cycles |
| src_mode_i | input | 2 | Data source: 0/3 ADC, 1 fixed, 2 counter |
| adc_i | input | CH_N*CH_W | Packed ADC channels, channel 0 in the low bits |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | End-of-run flag |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_addr_o | output | $clog2(DEPTH) | Buffer write address |
| wr_data_o | output | CH_N*CH_W | Buffer write word |

## Verification
The assertions check the properties of every cycle. These are: writes start at address zero and step by one without a gap until the last address, done rises only after the last write and never while busy, and a start during a run cannot end it. Other properties only show up across a whole run, so the bench scenarios have to cover them. These are the exact latency from trigger to first write (including the zero case), the placement of the pulse bit across the window, the contents of each source mode, and the absence of any effect from late triggers and restarts.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_LAT   = 2'd2,
    ST_WRITE = 2'd3
  } acq_state_e;

  typedef enum logic [1:0] {
    SRC_ADC   = 2'd0,
    SRC_FIXED = 2'd1,
    SRC_COUNT = 2'd2,
    SRC_ADC_B = 2'd3
  } src_mode_e;
endpackage

// File: rtl/acq_lat_timer.sv
module acq_lat_timer #(
  parameter int LAT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LAT_W-1:0] latency_i,
  input  logic             run_i,
  output logic             last_o
);
  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= latency_i - LAT_W'(1);
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - LAT_W'(1);
  end

  assign last_o = (cnt_q == LAT_W'(1));
endmodule

// File: rtl/acq_write_ctr.sv
module acq_write_ctr #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] idx_o,
  output logic          last_o,
  output logic          full_o
);
  // index plus a wrap flag in the top bit
  logic [AW:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i && !cnt_q[AW]) cnt_q <= cnt_q + (AW+1)'(1);
  end

  assign idx_o  = cnt_q[AW-1:0];
  assign full_o = cnt_q[AW];
  assign last_o = !cnt_q[AW] && (cnt_q[AW-1:0] == AW'(DEPTH-1));
endmodule

// File: rtl/acq_pulse_gen.sv
module acq_pulse_gen #(
  parameter int PULSE_LEN = 8,
  localparam int PW = $clog2(PULSE_LEN+1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (fire_i)      cnt_q <= PW'(PULSE_LEN);
    else if (cnt_q != '0) cnt_q <= cnt_q - PW'(1);
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/acq_test_src.sv
module acq_test_src
  import acq_pkg::*;
#(
  parameter int CH_N     = 8,
  parameter int CH_W     = 12,
  parameter int AW       = 9,
  parameter logic [CH_W-1:0] FIX_EVEN = CH_W'(12'h456),
  parameter logic [CH_W-1:0] FIX_ODD  = CH_W'(12'hABC),
  localparam int DW = CH_N*CH_W
) (
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] adc_i,
  input  logic [AW-1:0] idx_i,
  input  logic          pulse_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] fixed_w, count_w;
  src_mode_e mode;
  assign mode = src_mode_e'(mode_i);

  for (genvar k = 0; k < CH_N; k++) begin : g_ch
    logic [CH_W-1:0] fix_c, cnt_c;
    assign fix_c = (k % 2 == 0) ? FIX_EVEN : FIX_ODD;
    assign cnt_c = CH_W'(idx_i) + CH_W'(k);
    if (k == CH_N-1) begin : g_mark
      assign fixed_w[k*CH_W +: CH_W] = {pulse_i, fix_c[CH_W-2:0]};
      assign count_w[k*CH_W +: CH_W] = {pulse_i, cnt_c[CH_W-2:0]};
    end else begin : g_plain
      assign fixed_w[k*CH_W +: CH_W] = fix_c;
      assign count_w[k*CH_W +: CH_W] = cnt_c;
    end
  end

  always_comb begin
    unique case (mode)
      SRC_FIXED: data_o = fixed_w;
      SRC_COUNT: data_o = count_w;
      default:   data_o = adc_i;
    endcase
  end
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_pkg::*;
#(
  parameter int CH_N      = 8,
  parameter int CH_W      = 12,
  parameter int DEPTH     = 512,
  parameter int LAT_W     = 16,
  parameter int PULSE_LEN = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = CH_N*CH_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             soft_trig_i,
  input  logic             ext_trig_i,
  input  logic [LAT_W-1:0] latency_i,
  input  logic [1:0]       src_mode_i,
  input  logic [DW-1:0]    adc_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o
);
  acq_state_e state_q, state_d;
  logic done_q, done_d;
  logic trig, accept, lat_short, lat_last, wr_last, wr_full, pulse;

  assign trig      = soft_trig_i | ext_trig_i;
  assign accept    = (state_q == ST_ARMED) && trig;
  assign lat_short = (latency_i <= LAT_W'(1));

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) begin state_d = ST_ARMED; done_d = 1'b0; end
      ST_ARMED: if (trig) state_d = lat_short ? ST_WRITE : ST_LAT;
      ST_LAT:   if (lat_last) state_d = ST_WRITE;
      ST_WRITE: if (wr_last) begin state_d = ST_IDLE; done_d = 1'b1; end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  acq_lat_timer #(.LAT_W(LAT_W)) u_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .latency_i (latency_i),
    .run_i     (state_q == ST_LAT),
    .last_o    (lat_last)
  );

  acq_write_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_IDLE && start_i),
    .inc_i  (state_q == ST_WRITE),
    .idx_o  (wr_addr_o),
    .last_o (wr_last),
    .full_o (wr_full)
  );

  acq_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (accept),
    .pulse_o (pulse)
  );

  acq_test_src #(.CH_N(CH_N), .CH_W(CH_W), .AW(AW)) u_src (
    .mode_i  (src_mode_i),
    .adc_i   (adc_i),
    .idx_i   (wr_addr_o),
    .pulse_i (pulse),
    .data_o  (wr_data_o)
  );

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign wr_en_o = (state_q == ST_WRITE) && !wr_full;
endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          wr_en_o,
  input logic [AW-1:0] wr_addr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  a_r1_start_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o && !done_o);

  a_r4_first_addr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> wr_addr_o == '0);

  a_r4_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && $past(wr_en_o) |-> wr_addr_o == $past(wr_addr_o) + AW'(1));

  a_r4_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && wr_addr_o != LAST |=> wr_en_o);

  a_r5_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(wr_en_o) && $past(wr_addr_o) == LAST);

  a_r5_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r6_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !(wr_en_o && wr_addr_o == LAST) |=> busy_o);
endmodule

bind acq_sequencer acq_sequencer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o)
);

// File: tb/sim_acq_sequencer.sv
module sim_acq_sequencer;
  localparam int CLK_PERIOD = 25;
  localparam int CH_N = 8, CH_W = 12, DEPTH = 16, LAT_W = 8, PULSE_LEN = 5;
  localparam int AW = $clog2(DEPTH), DW = CH_N*CH_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, soft_trig = 0, ext_trig = 0;
  logic [LAT_W-1:0] latency = '0;
  logic [1:0] mode = '0;
  logic [DW-1:0] adc;
  logic busy, done, wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int cyc = 0, total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb
    for (int k = 0; k < CH_N; k++) adc[k*CH_W +: CH_W] = CH_W'(cyc*3 + k*37);

  acq_sequencer #(.CH_N(CH_N), .CH_W(CH_W), .DEPTH(DEPTH), .LAT_W(LAT_W),
                  .PULSE_LEN(PULSE_LEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .soft_trig_i(soft_trig),
    .ext_trig_i(ext_trig), .latency_i(latency), .src_mode_i(mode), .adc_i(adc),
    .busy_o(busy), .done_o(done), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data));

  // monitor state
  int n_wr = 0, first_cyc = -1, bad_addr = 0, bad_data = 0, bad_pulse = 0;
  int cur_lat = 1;
  logic [DW-1:0] mis_act, mis_exp;

  function automatic logic [DW-1:0] exp_word(int m, int i, int lc, logic [DW-1:0] a);
    logic [DW-1:0] w;
    if (m == 0 || m == 3) return a;
    for (int k = 0; k < CH_N; k++)
      w[k*CH_W +: CH_W] = (m == 1) ? ((k % 2 == 0) ? 12'h456 : 12'hABC) : CH_W'(i + k);
    w[DW-1] = (lc + i <= PULSE_LEN);
    return w;
  endfunction

  always @(negedge clk) begin
    if (wr_en) begin
      logic [DW-1:0] e;
      if (n_wr == 0) first_cyc = cyc;
      if (int'(wr_addr) != n_wr) bad_addr++;
      e = exp_word(int'(mode), n_wr, cur_lat, adc);
      if ((wr_data & ~(DW'(1) << (DW-1))) != (e & ~(DW'(1) << (DW-1)))) begin
        if (bad_data == 0) begin mis_act = wr_data; mis_exp = e; end
        bad_data++;
      end
      if ((mode == 1 || mode == 2) && wr_data[DW-1] != e[DW-1]) bad_pulse++;
      n_wr++;
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run(int m, int lat, bit use_ext, bit restart_mid, bit retrig);
    int tc, lc, guard;
    lc = (lat == 0) ? 1 : lat;
    @(negedge clk);
    mode = 2'(m); latency = LAT_W'(lat); cur_lat = lc;
    n_wr = 0; first_cyc = -1; bad_addr = 0; bad_data = 0; bad_pulse = 0;
    start = 1; tick(1); start = 0;
    check(busy && !done, "R1", "armed after start", {busy, done}, 2'b10);
    if (restart_mid) begin start = 1; tick(1); start = 0; end
    tick(3);
    check(n_wr == 0, "R2", "no write before trigger", n_wr, 0);
    tc = cyc;
    if (use_ext) ext_trig = 1; else soft_trig = 1;
    tick(1); ext_trig = 0; soft_trig = 0;
    if (retrig) begin tick(1); soft_trig = 1; tick(1); soft_trig = 0; end
    if (restart_mid) begin tick(lc + 2); start = 1; tick(1); start = 0; end
    if (retrig) begin tick(lc + 3); ext_trig = 1; tick(1); ext_trig = 0; end
    guard = 0;
    while (!done && guard < 400) begin tick(1); guard++; end
    check(first_cyc == tc + lc, "R3", $sformatf("first write lat=%0d", lat),
          first_cyc - tc, lc);
    check(n_wr == DEPTH && bad_addr == 0, "R4", "write count/addresses",
          n_wr, DEPTH);
    check(done && !busy, "R5", "done after window", {done, busy}, 2'b10);
    check(bad_data == 0, (m == 1) ? "R9" : (m == 2) ? "R10" : "R8",
          $sformatf("data mode %0d", m), mis_act, mis_exp);
    if (m == 1 || m == 2)
      check(bad_pulse == 0, "R11", $sformatf("pulse bit lat=%0d", lat), bad_pulse, 0);
    if (restart_mid) check(first_cyc == tc + lc && n_wr == DEPTH, "R6",
                           "start during run ignored", n_wr, DEPTH);
    if (retrig) check(first_cyc == tc + lc && bad_pulse == 0 && n_wr == DEPTH, "R7",
                      "late trigger ignored", bad_pulse, 0);
    tick(4);
    check(done && !busy, "R5", "done held", {done, busy}, 2'b10);
  endtask

  initial begin
    tick(2);
    check(!busy && !done && !wr_en, "R1", "reset state", {busy, done, wr_en}, 0);
    rst_n = 1;
    tick(2);
    soft_trig = 1; ext_trig = 1; tick(1); soft_trig = 0; ext_trig = 0;
    tick(6);
    check(!busy && n_wr == 0, "R2", "trigger while idle", n_wr, 0);
    for (int l = 0; l <= 8; l++) run(1, l, l[0], 0, 0);
    for (int l = 1; l <= 7; l += 3) run(2, l, 0, 0, 0);
    run(0, 2, 1, 0, 0);
    run(3, 1, 0, 0, 0);
    run(2, 4, 0, 1, 0);
    run(1, 3, 1, 0, 1);
    run(2, 20, 0, 1, 1);
    n_wr = 0;
    soft_trig = 1; tick(1); soft_trig = 0; tick(6);
    check(!busy && done && n_wr == 0, "R2", "trigger after done", n_wr, 0);
    @(negedge clk); start = 1; tick(1); start = 0;
    check(busy && !done, "R1", "restart clears done", {busy, done}, 2'b10);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule